// File: doc/BRIEF.md
# Power-Down Pin and State Hold Controller

This block sits between the package pins and a logic core. It lets two dedicated pins put the core into a frozen state. When the feature is enabled and either power-down pin is high, the controller does four things. It stops the core's clock enable. It presents the core with the pin values captured when the hold began, so later pin activity does not reach the core. It drives the output pins and their enables from a snapshot taken on the same edge. While the feature is enabled, the two pins are also withdrawn from general logic use.

The power-down pins are asynchronous to the core clock, so each one passes through a two-flop synchroniser first. A hold register then acts on the synchronised values. The hold starts on the third rising edge after a pin rises, and ends on the third rising edge after the last pin falls. An asynchronous active-low power-on reset clears every register in the block to zero. When the feature bit is low, the two pins are forwarded to the core as ordinary inputs and the hold is never entered.

Top module: `pd_hold_wrap`

## Requirements
- R1: While `rst_n` is low and after it is released, all registers read zero: `core_in` is 0, `hold_active` is 0 and `core_ce` is 1 until a hold is requested.
- R2: With `pd_feature_en` high, a pin (`pd_a` or `pd_b`) that is seen high at rising edge k makes `hold_active` go high after rising edge k+2.
- R3: `hold_active` goes low after the rising edge that follows the edge at which both synchronised pins are seen low, which is the third edge after the last pin is sampled low.
- R4: Outside a hold, `core_in` equals the `pin_in` sampled at the previous rising edge. During a hold, `core_in` keeps the value captured at the edge on which the hold began.
- R5: `core_ce` is low exactly while `hold_active` is high.
- R6: Outside a hold, `pin_out` and `pin_oe` follow `core_out` and `core_oe` with no delay. During a hold, they keep the values the core presented just before the entry edge, whatever the core drives afterwards.
- R7: An output bit whose `core_oe` was 0 at hold entry keeps `pin_oe` at 0 (high impedance) for the whole hold.
- R8: With `pd_feature_en` low, `hold_active` stays low whatever the pins do, and `pd_a_in`/`pd_b_in` equal `pd_a`/`pd_b`.
- R9: With `pd_feature_en` high, `pd_a_in` and `pd_b_in` read 0.
- R10: Either pin alone starts a hold, and the hold lasts as long as either synchronised pin is high. Clearing the feature bit during a hold ends it on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pd_feature_en | input | 1 | Configuration bit enabling the power-down function |
| pd_a | input | 1 | First power-down pin (asynchronous) |
| pd_b | input | 1 | Second power-down pin (asynchronous) |
| pin_in | input | IN_W | Raw input pin values |
| core_out | input | OUT_W | Output values from the core |
| core_oe | input | OUT_W | Output enables from the core (1 = drive) |
| core_in | output | IN_W | Registered, hold-aware input values to the core |
| core_ce | output | 1 | Clock enable for the core registers |
| pin_out | output | OUT_W | Values to the output pin drivers |
| pin_oe | output | OUT_W | Enables to the output pin drivers |
| pd_a_in | output | 1 | `pd_a` as a logic input (0 while the feature is on) |
| pd_b_in | output | 1 | `pd_b` as a logic input (0 while the feature is on) |
| hold_active | output | 1 | High while the hold is in force |

## Verification
The bench drives a number of pin patterns:
- Single pulses on each pin alone, which separate a one-pin hold from an OR of both pins.
- Overlapping pulses where one pin falls while the other is still high, which show whether exit waits for both pins.
- One-cycle pulses, which show the exact synchroniser latency.
- Feature-bit changes both before and during a hold, which separate the pass-through mode from the hold mode.

During each hold, the bench keeps changing `pin_in`, `core_out` and `core_oe`. A leak through any frozen path therefore shows as a mismatch against the behavioural model. Output enables with zero bits at entry check that undriven pins stay undriven.

// File: rtl/pdh_pkg.sv
package pdh_pkg;

  // A hold is wanted when the feature is on and either synchronised pin is high.
  function automatic logic hold_wanted(input logic feat_en, input logic [1:0] pins_sync);
    return feat_en & (|pins_sync);
  endfunction

  // Both synchronised pins are low.
  function automatic logic pins_quiet(input logic [1:0] pins_sync);
    return ~(|pins_sync);
  endfunction

  // A pin as seen by the core's logic: masked to 0 while the feature owns it.
  function automatic logic pin_as_logic(input logic feat_en, input logic raw);
    return raw & ~feat_en;
  endfunction

endpackage

// File: rtl/pdh_sync.sv
module pdh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], d};
  end

  assign q = chain[LAST];
endmodule

// File: rtl/pdh_snap.sv
module pdh_snap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/pdh_hold_ctl.sv
module pdh_hold_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       feat_en,
  input  logic [1:0] pins_sync,
  output logic       hold_q
);
  import pdh_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_wanted(feat_en, pins_sync);
  end
endmodule

// File: rtl/pd_hold_wrap.sv
module pd_hold_wrap #(
  parameter int IN_W        = 8,
  parameter int OUT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_feature_en,
  input  logic             pd_a,
  input  logic             pd_b,
  input  logic [IN_W-1:0]  pin_in,
  input  logic [OUT_W-1:0] core_out,
  input  logic [OUT_W-1:0] core_oe,
  output logic [IN_W-1:0]  core_in,
  output logic             core_ce,
  output logic [OUT_W-1:0] pin_out,
  output logic [OUT_W-1:0] pin_oe,
  output logic             pd_a_in,
  output logic             pd_b_in,
  output logic             hold_active
);
  import pdh_pkg::*;

  localparam int NPD   = 2;
  localparam int SNAPW = 2 * OUT_W;

  logic [NPD-1:0]   pd_raw;
  logic [NPD-1:0]   pd_sync;
  logic             hold_q;
  logic             capture_en;  // named event: snapshot registers may load
  logic             pd_quiet;    // named event: both synchronised pins low
  logic [SNAPW-1:0] snap_q;

  assign pd_raw = {pd_b, pd_a};

  for (genvar g = 0; g < NPD; g++) begin : g_sync
    pdh_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pd_raw[g]),
      .q    (pd_sync[g])
    );
  end

  pdh_hold_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .feat_en  (pd_feature_en),
    .pins_sync(pd_sync),
    .hold_q   (hold_q)
  );

  assign capture_en = ~hold_q;
  assign pd_quiet   = pins_quiet(pd_sync);

  pdh_snap #(.W(IN_W)) u_in_snap (
    .clk  (clk),
    .rst_n(rst_n),
    .cap  (capture_en),
    .d    (pin_in),
    .q    (core_in)
  );

  pdh_snap #(.W(SNAPW)) u_out_snap (
    .clk  (clk),
    .rst_n(rst_n),
    .cap  (capture_en),
    .d    ({core_oe, core_out}),
    .q    (snap_q)
  );

  always_comb begin
    if (hold_q) begin
      pin_out = snap_q[OUT_W-1:0];
      pin_oe  = snap_q[SNAPW-1:OUT_W];
    end else begin
      pin_out = core_out;
      pin_oe  = core_oe;
    end
  end

  assign core_ce     = capture_en;
  assign hold_active = hold_q;
  assign pd_a_in     = pin_as_logic(pd_feature_en, pd_a);
  assign pd_b_in     = pin_as_logic(pd_feature_en, pd_b);
endmodule

// File: rtl/pd_hold_wrap_chk.sv
module pd_hold_wrap_chk #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_feature_en,
  input logic             pd_a,
  input logic             pd_b,
  input logic [IN_W-1:0]  core_in,
  input logic [OUT_W-1:0] pin_out,
  input logic [OUT_W-1:0] pin_oe,
  input logic             pd_a_in,
  input logic             pd_b_in,
  input logic             hold_active,
  input logic             pd_quiet
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (core_in == '0 && !hold_active); // R1
    end
  end

  AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && pd_quiet) |=> !hold_active); // R3

  AST_INPUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |=> (!hold_active || $stable(core_in))); // R4

  AST_OUTPUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |=> (!hold_active || ($stable(pin_out) && $stable(pin_oe)))); // R6

  AST_NO_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_feature_en |=> !hold_active); // R8

  AST_PINS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    pd_feature_en |-> (!pd_a_in && !pd_b_in)); // R9

  AST_OE_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && $past(hold_active)) |-> ((pin_oe & ~$past(pin_oe)) == '0)); // R7
endmodule

bind pd_hold_wrap pd_hold_wrap_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pd_feature_en(pd_feature_en),
  .pd_a         (pd_a),
  .pd_b         (pd_b),
  .core_in      (core_in),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe),
  .pd_a_in      (pd_a_in),
  .pd_b_in      (pd_b_in),
  .hold_active  (hold_active),
  .pd_quiet     (pd_quiet)
);

// File: tb/test_pd_hold_wrap.sv
module test_pd_hold_wrap;
  localparam int IN_W  = 8;
  localparam int OUT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pd_feature_en = 1'b0;
  logic             pd_a = 1'b0;
  logic             pd_b = 1'b0;
  logic [IN_W-1:0]  pin_in = '0;
  logic [OUT_W-1:0] core_out = '0;
  logic [OUT_W-1:0] core_oe = '0;
  logic [IN_W-1:0]  core_in;
  logic             core_ce;
  logic [OUT_W-1:0] pin_out;
  logic [OUT_W-1:0] pin_oe;
  logic             pd_a_in;
  logic             pd_b_in;
  logic             hold_active;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;
  string phase_tag = "R1";

  always #10 clk = ~clk;  // 50 MHz

  pd_hold_wrap #(.IN_W(IN_W), .OUT_W(OUT_W)) i_pd_hold_wrap (
    .clk(clk), .rst_n(rst_n), .pd_feature_en(pd_feature_en),
    .pd_a(pd_a), .pd_b(pd_b), .pin_in(pin_in),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .core_ce(core_ce), .pin_out(pin_out), .pin_oe(pin_oe),
    .pd_a_in(pd_a_in), .pd_b_in(pd_b_in), .hold_active(hold_active)
  );

  // Behavioural reference: hold at edge k = enable(k) AND pin-OR seen at edge k-2.
  int         pin_hist[$];
  bit         m_hold;
  bit [7:0]   m_in, m_out, m_oe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_hist = '{0, 0};
      m_hold = 0; m_in = 0; m_out = 0; m_oe = 0;
    end else begin
      if (!m_hold) begin
        m_in = pin_in; m_out = core_out; m_oe = core_oe;
      end
      m_hold = pd_feature_en && (pin_hist[0] != 0);
      pin_hist.push_back((pd_a || pd_b) ? 1 : 0);
      void'(pin_hist.pop_front());
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(phase_tag, "hold_active", hold_active, m_hold);
    check("R4", "core_in", core_in, m_in);
    check("R5", "core_ce", core_ce, !m_hold);
    check("R6", "pin_out", pin_out, m_hold ? m_out : core_out);
    check("R6", "pin_oe", pin_oe, m_hold ? m_oe : core_oe);
    check(pd_feature_en ? "R9" : "R8", "pd_a_in", pd_a_in, pd_feature_en ? 0 : pd_a);
    check(pd_feature_en ? "R9" : "R8", "pd_b_in", pd_b_in, pd_feature_en ? 0 : pd_b);
  endtask

  // One clock: compare at the falling edge, then drive new inputs.
  task automatic step(bit a, bit b, bit scramble);
    @(negedge clk);
    compare_all();
    pd_a = a; pd_b = b;
    if (scramble) begin
      pin_in = 8'($urandom); core_out = 8'($urandom); core_oe = 8'($urandom);
    end
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    mismatched++;
    compared++;
    $display("FAIL watchdog expired: actual %0d expected <100000 cycles", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    bit [7:0] oe_at_entry;
    void'($urandom(17));
    repeat (3) @(negedge clk);
    check("R1", "core_in in reset", core_in, 0);
    check("R1", "hold_active in reset", hold_active, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "core_ce after reset", core_ce, 1);
    check("R1", "core_in after reset", core_in, 0);

    // Normal operation, feature on, pins low.
    pd_feature_en = 1'b1;
    phase_tag = "R9";
    for (int i = 0; i < 20; i++) step(0, 0, 1);

    // pd_a alone: entry then exit.
    phase_tag = "R2";
    for (int i = 0; i < 10; i++) step(1, 0, 1);
    phase_tag = "R3";
    for (int i = 0; i < 6; i++) step(0, 0, 1);

    // pd_b alone, then overlap where pd_a falls while pd_b stays high.
    phase_tag = "R10";
    for (int i = 0; i < 8; i++) step(0, 1, 1);
    for (int i = 0; i < 4; i++) step(1, 1, 1);
    for (int i = 0; i < 6; i++) step(0, 1, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 1);

    // Short single-cycle pulse.
    phase_tag = "R2";
    step(1, 0, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 1);

    // R7: enables partly off at entry; pins with oe=0 must stay undriven.
    phase_tag = "R7";
    @(negedge clk);
    compare_all();
    core_oe = 8'h0F; core_out = 8'h5A; pd_a = 1'b1;
    oe_at_entry = 8'h0F;
    step(1, 0, 0);
    step(1, 0, 0);
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 0);
      core_oe = 8'hFF; core_out = 8'($urandom);
      #1;
      check("R7", "oe off bits stay off", pin_oe & ~oe_at_entry, 0);
      check("R7", "hold kept", hold_active, 1);
    end
    for (int i = 0; i < 6; i++) step(0, 0, 1);

    // Feature off: pins are ordinary inputs, no hold.
    pd_feature_en = 1'b0;
    phase_tag = "R8";
    for (int i = 0; i < 6; i++) step(1, 0, 1);
    for (int i = 0; i < 6; i++) step(0, 1, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1);

    // Feature bit dropped during a hold ends it on the next edge.
    pd_feature_en = 1'b1;
    phase_tag = "R10";
    for (int i = 0; i < 8; i++) step(1, 1, 1);
    @(negedge clk);
    compare_all();
    pd_feature_en = 1'b0;
    for (int i = 0; i < 4; i++) step(1, 1, 1);
    pd_feature_en = 1'b1;
    for (int i = 0; i < 6; i++) step(0, 0, 1);

    // Soak with random pin activity.
    phase_tag = "R2";
    for (int i = 0; i < 400; i++) begin
      bit a = ($urandom % 6) == 0;
      bit b = ($urandom % 9) == 0;
      step(a, b, 1);
    end
    for (int i = 0; i < 4; i++) step(0, 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule